// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Target

This block is the serial-bus end of a device whose configuration and results sit in a bank of 16-bit registers. It works on SCL and SDA samples that have already been synchronised to the system clock. It pulls SDA low through an open-drain enable and never drives it high. Toward the device core it presents one register port: an address, a write word with a one-cycle write strobe, and a read word with a one-cycle read strobe.

A bus master first writes an 8-bit pointer. The pointer is the first byte after the 7-bit target address with the write direction. Any further bytes in the same transaction are data for the register the pointer selects, two bytes per word with the high byte first. A read transaction always returns the register named by the last accepted pointer. The pointer never advances on its own, so a master that keeps acknowledging reads the same register again. Two identification words are answered by the block itself and reject writes. Pointers between the core range and the identification words are refused.

The core port has no back-pressure. `reg_rdata` must hold the word for `reg_addr` in the same cycle that `reg_re` is high, and `reg_we` is a single-cycle strobe that the core must accept when it arrives. All bytes on the bus travel MSB first.

Top module: `i2c_ptr_target`

## Requirements
- R1: An address byte whose upper seven bits equal 1010000 is acknowledged by holding SDA low through the ninth clock; bit 0 of that byte is the direction (0 write, 1 read). Any other address is not acknowledged, and the block ignores the bus until the next start.
- R2: The first byte after a write-direction address is the pointer. After reset the pointer is 0x00. Pointers 0x00 to 0x14, 0xFE and 0xFF are acknowledged and loaded. Pointers 0x15 to 0xFD are not acknowledged, leave the pointer unchanged, and cause the rest of that transaction to be ignored.
- R3: A write transaction may stop right after the pointer byte. A later read uses that pointer. The pointer does not advance between or within transactions.
- R4: Write data arrives as two bytes, high byte first. After the second acknowledged byte, `reg_we` pulses for exactly one cycle with `reg_addr` equal to the pointer and `reg_wdata` holding the full word. Further byte pairs in the same transaction write the same register again.
- R5: A stop after only one data byte of a word produces no write strobe, and the register keeps its value.
- R6: When the pointer is 0xFE or 0xFF, every data byte written is not acknowledged and no write strobe is issued.
- R7: A read returns the word at the pointer, high byte then low byte, each MSB first. `reg_re` pulses once per word, in the cycle the word is taken from `reg_rdata`.
- R8: Pointer 0xFE reads 0x5449 and pointer 0xFF reads 0x1004. These words come from the block itself, with no `reg_re` pulse.
- R9: If the master acknowledges the low byte, the same register is read again, with a fresh `reg_re`. If the master does not acknowledge a byte, the block releases SDA and idles until the next start.
- R10: A repeated start returns the block to address matching and keeps the pointer.
- R11: The block starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample (wired bus level) |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | 8 | Register address (current pointer) |
| reg_wdata | output | 16 | Write word, valid with `reg_we` |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe; `reg_rdata` sampled in this cycle |
| reg_rdata | input | 16 | Read word for `reg_addr`, combinational from the core |

## Verification
Bus conditions and word completion can collide. A stop or repeated start can arrive while a word is half-assembled, in the same SCL phase in which the byte counter would otherwise advance toward a strobe. The bench provokes this by stopping after one data byte, and by issuing a repeated start straight after a pointer byte. A scoreboard of expected writes, together with a read-back of the old value, shows that no strobe escaped. A second overlap is the word reload after a master acknowledge, where the read strobe and the first bit of the next word share a cycle. Multi-word reads check both the byte stream and the count of read strobes.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_MACK
  } tgt_state_e;

  // pointer lies in the core-backed range
  function automatic logic ptr_in_core(input logic [PTR_W-1:0] p,
                                       input logic [PTR_W-1:0] last_rw);
    return p <= last_rw;
  endfunction

  // pointer names one of the built-in identification words
  function automatic logic ptr_in_id(input logic [PTR_W-1:0] p,
                                     input logic [PTR_W-1:0] id_base,
                                     input int num_id);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < num_id; k++)
      if (p == id_base + PTR_W'(k)) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_rsp_select.sv
module i2c_rsp_select
  import i2c_tgt_pkg::*;
#(
  parameter int                       DATA_W  = 16,
  parameter logic [PTR_W-1:0]         LAST_RW = 8'h14,
  parameter logic [PTR_W-1:0]         ID_BASE = 8'hFE,
  parameter int                       NUM_ID  = 2,
  parameter logic [NUM_ID*DATA_W-1:0] ID_VALS = {16'h5449, 16'h1004}
) (
  input  logic [PTR_W-1:0]  ptr,
  input  logic [DATA_W-1:0] core_word,
  output logic              sel_core,
  output logic              sel_ro,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] id_word;

  // identification words, first listed value sits at ID_BASE
  always_comb begin
    id_word = '0;
    for (int k = 0; k < NUM_ID; k++)
      if (ptr == ID_BASE + PTR_W'(k))
        id_word = ID_VALS[(NUM_ID-1-k)*DATA_W +: DATA_W];
  end

  assign sel_core = ptr_in_core(ptr, LAST_RW);
  assign sel_ro   = ptr_in_id(ptr, ID_BASE, NUM_ID);
  assign rd_word  = sel_core ? core_word : id_word;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int               DATA_W   = 16,
  parameter logic [6:0]       TGT_ADDR = 7'b1010000,
  parameter logic [PTR_W-1:0] LAST_RW  = 8'h14,
  parameter logic [PTR_W-1:0] ID_BASE  = 8'hFE,
  parameter int               NUM_ID   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              cur_core,
  input  logic              cur_ro,
  input  logic [DATA_W-1:0] rd_word,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [DATA_W-1:0] wbuf_q,
  output logic              we_q,
  output logic              re_q
);
  localparam int NBYTE = DATA_W / BYTE_W;
  localparam int BCW   = $clog2(BYTE_W + 1);
  localparam int BIW   = (NBYTE > 1) ? $clog2(NBYTE) : 1;
  localparam logic [BCW-1:0] BITS_FULL = BCW'(BYTE_W);
  localparam logic [BIW-1:0] LAST_BYTE = BIW'(NBYTE - 1);

  tgt_state_e        state_q;
  logic [BCW-1:0]    bit_cnt;
  logic [BYTE_W-1:0] sh_q;
  logic [BIW-1:0]    byte_idx;
  logic [DATA_W-1:0] tx_q;
  logic              ack_drv, rnw_q, mack_q;
  logic              byte_end;

  assign byte_end = scl_fall && (bit_cnt == BITS_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bit_cnt  <= '0;
      sh_q     <= '0;
      ptr_q    <= '0;
      byte_idx <= '0;
      wbuf_q   <= '0;
      tx_q     <= '0;
      ack_drv  <= 1'b0;
      rnw_q    <= 1'b0;
      mack_q   <= 1'b0;
      we_q     <= 1'b0;
      re_q     <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (start_det) begin
        // start and repeated start both restart address matching
        state_q  <= ST_ADDR;
        bit_cnt  <= '0;
        byte_idx <= '0;
        ack_drv  <= 1'b0;
      end else if (stop_det) begin
        state_q  <= ST_IDLE;
        byte_idx <= '0;
        ack_drv  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_PTR, ST_WR: begin
            if (scl_rise) begin
              sh_q    <= {sh_q[BYTE_W-2:0], sda_i};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_end) begin
              bit_cnt <= '0;
              if (state_q == ST_ADDR) begin
                if (sh_q[7:1] == TGT_ADDR) begin
                  rnw_q   <= sh_q[0];
                  ack_drv <= 1'b1;
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_PTR) begin
                if (ptr_in_core(sh_q, LAST_RW) || ptr_in_id(sh_q, ID_BASE, NUM_ID)) begin
                  ptr_q   <= sh_q;
                  ack_drv <= 1'b1;
                  state_q <= ST_PTR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                state_q <= ST_WR_ACK;
                ack_drv <= !cur_ro;
                wbuf_q  <= {wbuf_q[DATA_W-BYTE_W-1:0], sh_q};
                if (byte_idx == LAST_BYTE) begin
                  byte_idx <= '0;
                  we_q     <= !cur_ro;
                end else begin
                  byte_idx <= byte_idx + 1'b1;
                end
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              ack_drv <= 1'b0;
              if (rnw_q) begin
                tx_q     <= rd_word;
                re_q     <= cur_core;
                byte_idx <= '0;
                state_q  <= ST_RD;
              end else begin
                state_q <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK: begin
            if (scl_fall) begin
              ack_drv  <= 1'b0;
              byte_idx <= '0;
              state_q  <= ST_WR;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              ack_drv <= 1'b0;
              state_q <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              tx_q <= tx_q << 1;
              if (bit_cnt == BITS_FULL) begin
                bit_cnt <= '0;
                state_q <= ST_RD_MACK;
              end
            end
          end
          ST_RD_MACK: begin
            if (scl_rise) begin
              mack_q <= !sda_i;
            end else if (scl_fall) begin
              if (mack_q) begin
                state_q <= ST_RD;
                if (byte_idx == LAST_BYTE) begin
                  // no auto-increment: the same word is fetched again
                  byte_idx <= '0;
                  tx_q     <= rd_word;
                  re_q     <= cur_core;
                end else begin
                  byte_idx <= byte_idx + 1'b1;
                end
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = ack_drv | ((state_q == ST_RD) & ~tx_q[DATA_W-1]);

  p_drive_on_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  p_ptr_only_in_ptr_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr_q) |-> $past(state_q) == ST_PTR);

  p_we_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
  import i2c_tgt_pkg::*;
#(
  parameter int                       DATA_W   = 16,
  parameter logic [6:0]               TGT_ADDR = 7'b1010000,
  parameter logic [PTR_W-1:0]         LAST_RW  = 8'h14,
  parameter logic [PTR_W-1:0]         ID_BASE  = 8'hFE,
  parameter int                       NUM_ID   = 2,
  parameter logic [NUM_ID*DATA_W-1:0] ID_VALS  = {16'h5449, 16'h1004}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic scl_rise, scl_fall, start_det, stop_det;
  logic cur_core, cur_ro;
  logic [DATA_W-1:0] rd_word;

  i2c_line_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rsp_select #(
    .DATA_W  (DATA_W),
    .LAST_RW (LAST_RW),
    .ID_BASE (ID_BASE),
    .NUM_ID  (NUM_ID),
    .ID_VALS (ID_VALS)
  ) u_rsp (
    .ptr       (reg_addr),
    .core_word (reg_rdata),
    .sel_core  (cur_core),
    .sel_ro    (cur_ro),
    .rd_word   (rd_word)
  );

  i2c_tgt_ctrl #(
    .DATA_W   (DATA_W),
    .TGT_ADDR (TGT_ADDR),
    .LAST_RW  (LAST_RW),
    .ID_BASE  (ID_BASE),
    .NUM_ID   (NUM_ID)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .cur_core  (cur_core),
    .cur_ro    (cur_ro),
    .rd_word   (rd_word),
    .sda_oe    (sda_oe),
    .ptr_q     (reg_addr),
    .wbuf_q    (reg_wdata),
    .we_q      (reg_we),
    .re_q      (reg_re)
  );

  p_re_core_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> reg_addr <= LAST_RW);

  p_we_not_readonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> reg_addr <= LAST_RW);
endmodule

// File: tb/i2c_ptr_target_test.sv
module i2c_ptr_target_test;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we, reg_re;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic sda_bus;

  logic [15:0] core_mem [0:20];
  logic [15:0] exp_mem  [0:20];
  logic [23:0] wq [$];
  int checks = 0, fails = 0, re_cnt = 0, r11_viol = 0;
  bit  done = 1'b0;
  logic oe_prev = 1'b0;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;
  assign reg_rdata = (reg_addr <= 8'h14) ? core_mem[reg_addr[4:0]] : 16'hDEAD;

  i2c_ptr_target uut (
    .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_bus),
    .sda_oe (sda_oe), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .reg_we (reg_we), .reg_re (reg_re), .reg_rdata (reg_rdata)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: write scoreboard, read strobe count, drive-timing watch
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_we) begin
        if (wq.size() == 0) begin
          check(1'b0, "R4/R5/R6 unexpected write", {reg_addr, reg_wdata}, 0);
        end else begin
          logic [23:0] e;
          e = wq.pop_front();
          check({reg_addr, reg_wdata} == e, "R4 write word", {reg_addr, reg_wdata}, e);
        end
        core_mem[reg_addr[4:0]] <= reg_wdata;
      end
      if (reg_re) re_cnt++;
      if (sda_oe && !oe_prev && scl_m) r11_viol++;
      oe_prev <= sda_oe;
    end
  end

  task automatic hold(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold(); sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0;
    end
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
    ack = !sda_bus;
    scl_m = 1'b0; hold();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    for (int i = 7; i >= 0; i--) begin
      hold(); scl_m = 1'b1; hold(); b[i] = sda_bus; scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0; sda_m = 1'b1; hold();
  endtask

  task automatic set_ptr(input logic [7:0] p, input bit exp_ack, input string tag);
    bit a;
    i2c_start();
    send_byte(8'hA0, a); check(a, {tag, " address ack R1"}, a, 1);
    send_byte(p, a);     check(a == exp_ack, {tag, " pointer ack R2"}, a, exp_ack);
    i2c_stop();
  endtask

  task automatic write_word(input logic [7:0] p, input logic [15:0] d);
    bit a;
    wq.push_back({p, d});
    exp_mem[p[4:0]] = d;
    i2c_start();
    send_byte(8'hA0, a); check(a, "R1 write address ack", a, 1);
    send_byte(p, a);     check(a, "R2 pointer ack", a, 1);
    send_byte(d[15:8], a); check(a, "R4 high byte ack", a, 1);
    send_byte(d[7:0], a);  check(a, "R4 low byte ack", a, 1);
    i2c_stop();
  endtask

  // read nwords copies of the current register and compare each
  task automatic read_words(input logic [15:0] exp, input int nwords, input string tag);
    bit a;
    logic [7:0] hi, lo;
    i2c_start();
    send_byte(8'hA1, a); check(a, {tag, " read address ack R1"}, a, 1);
    for (int w = 0; w < nwords; w++) begin
      recv_byte(hi, 1'b1);
      recv_byte(lo, w != nwords - 1);
      check({hi, lo} == exp, tag, {hi, lo}, exp);
    end
    i2c_stop();
  endtask

  initial begin
    for (int i = 0; i <= 20; i++) begin
      core_mem[i] = 16'h1000 + 16'(i) * 16'h0111;
      exp_mem[i]  = 16'h1000 + 16'(i) * 16'h0111;
    end
    repeat (3) @(negedge clk);
    check(sda_oe == 0 && reg_we == 0 && reg_re == 0, "reset outputs idle",
          {sda_oe, reg_we, reg_re}, 0);
    rst_n = 1'b1;
    hold();

    begin : body
      bit a;
      int re0;
      // R2: pointer resets to 0x00
      re0 = re_cnt;
      read_words(exp_mem[0], 1, "R2 reset pointer reads reg 0");
      check(re_cnt - re0 == 1, "R7 one read strobe per word", re_cnt - re0, 1);

      write_word(8'h08, 16'h1C55);
      // R3: pointer-only write then read
      set_ptr(8'h08, 1'b1, "R3");
      read_words(16'h1C55, 1, "R3 R7 read after pointer-only write");
      // R9: master ack reloads same register, no auto-increment
      re0 = re_cnt;
      read_words(16'h1C55, 3, "R9 R3 repeated word");
      check(re_cnt - re0 == 3, "R9 read strobe per repeated word", re_cnt - re0, 3);

      // R1: wrong address not acknowledged
      i2c_start();
      send_byte(8'hA2, a); check(!a, "R1 wrong address nack", a, 0);
      send_byte(8'h02, a); check(!a, "R1 ignored after nack", a, 0);
      i2c_stop();

      // R2: unused pointers refused, pointer kept
      set_ptr(8'h15, 1'b0, "R2 0x15");
      set_ptr(8'hFD, 1'b0, "R2 0xFD");
      read_words(16'h1C55, 1, "R2 pointer kept after refusal");

      // boundary core register, two pairs in one transaction
      wq.push_back({8'h14, 16'hA5C3});
      wq.push_back({8'h14, 16'h0F0F});
      exp_mem[20] = 16'h0F0F;
      i2c_start();
      send_byte(8'hA0, a); send_byte(8'h14, a); check(a, "R2 0x14 ack", a, 1);
      send_byte(8'hA5, a); send_byte(8'hC3, a);
      send_byte(8'h0F, a); send_byte(8'h0F, a); check(a, "R4 second pair ack", a, 1);
      i2c_stop();
      read_words(exp_mem[20], 1, "R4 same register rewritten");

      // R6: identification words reject writes
      i2c_start();
      send_byte(8'hA0, a); send_byte(8'hFE, a); check(a, "R2 0xFE pointer ack", a, 1);
      send_byte(8'h12, a); check(!a, "R6 data byte nack 1", a, 0);
      send_byte(8'h34, a); check(!a, "R6 data byte nack 2", a, 0);
      i2c_stop();
      re0 = re_cnt;
      read_words(16'h5449, 1, "R8 id at 0xFE");
      set_ptr(8'hFF, 1'b1, "R8");
      read_words(16'h1004, 2, "R8 id at 0xFF");
      check(re_cnt == re0, "R8 no read strobe for id", re_cnt - re0, 0);

      // R5: stop after one data byte
      i2c_start();
      send_byte(8'hA0, a); send_byte(8'h03, a);
      send_byte(8'h77, a); check(a, "R5 lone byte ack", a, 1);
      i2c_stop();
      // R10: repeated start after pointer, pointer 0x03 kept
      i2c_start();
      send_byte(8'hA0, a); send_byte(8'h03, a);
      begin
        logic [7:0] hi, lo;
        i2c_start();
        send_byte(8'hA1, a); check(a, "R10 address ack after repeated start", a, 1);
        recv_byte(hi, 1'b1); recv_byte(lo, 1'b0);
        check({hi, lo} == exp_mem[3], "R5 R10 register 3 unchanged", {hi, lo}, exp_mem[3]);
        i2c_stop();
      end
      hold();
      check(wq.size() == 0, "R4 all expected writes seen", wq.size(), 0);
      check(r11_viol == 0, "R11 drive starts with SCL low", r11_viol, 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule